// File: doc/BRIEF.md
# Streaming Hamming Parity Generator for Flash Page Data

This block sits on the byte path between a host and a NAND flash device. It watches every byte that passes with its valid strobe and builds a Hamming-style parity code on the fly. The code is built over fixed 256-byte chunks and no byte is stalled or buffered. Each set data bit contributes its 11-bit address {byte index, bit index} to a "direct" parity word and the bitwise complement of that address to a "complement" parity word. If a single bit flips between a written page and the same page read back, the XOR of the two codes therefore names the flipped bit. The low three bits give its bit position and the upper eight give its byte position.

A page-size select chooses between one chunk (256-byte pages) and two chunks (512-byte pages). Each chunk has its own pair of parity registers and its own packed 22-bit code. A clear request restarts the byte position at zero and zeroes every accumulator. A busy flag stays high while clearing is in progress, and bytes offered during that time are dropped.

Top module: `chunk_ecc_gen`

## Requirements
- R1: After reset, every parity output and packed code is zero and `clr_busy` is 0.
- R2: Each accepted byte at chunk position i XORs, into that chunk's `par_lo` word, the 11-bit value {i[7:0], k[2:0]} for every set data bit k. The result appears at the outputs one clock after the byte is accepted.
- R3: The same byte XORs the bitwise complement of each such address into the chunk's `par_hi` word. So `par_hi ^ par_lo` is all ones when the chunk holds an odd number of set bits, and zero when it holds an even number.
- R4: The packed code of chunk c is `code[c*22 +: 22]`, with `par_lo` in bits [10:0] and `par_hi` in bits [21:11].
- R5: Chunk position counts accepted bytes and wraps every 256. With `page_wide`=1, bytes 0–255 of the page go to chunk 0 and bytes 256–511 go to chunk 1.
- R6: With `page_wide`=0, only the first 256 accepted bytes are used. Chunk 1 stays zero and later bytes change nothing until the next clear.
- R7: With `page_wide`=1, bytes after the 512th are ignored until the next clear.
- R8: A `clr_req` pulse zeroes all accumulators and the byte position on that clock edge. `clr_busy` then reads 1 for exactly two cycles.
- R9: A byte offered while `clr_req` or `clr_busy` is high is dropped. The first byte accepted after the clear is byte 0.
- R10: For two 256-byte streams that differ in one data bit at byte b, bit k, the XOR of the two chunk-0 codes has {b, k} in bits [10:0] and its complement in bits [21:11].
- R11: A cycle with no valid byte and no clear leaves every parity word unchanged. There is no backpressure: one byte is taken per valid cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_req | input | 1 | One-cycle request to clear accumulators and position |
| clr_busy | output | 1 | High while a clear is in progress |
| page_wide | input | 1 | 1: two chunks (512-byte page), 0: one chunk |
| byte_vld | input | 1 | Byte strobe |
| byte_dat | input | 8 | Data byte |
| par_lo | output | 22 | Direct parity words, chunk c at [c*11 +: 11] |
| par_hi | output | 22 | Complement parity words, chunk c at [c*11 +: 11] |
| code | output | 44 | Packed codes, chunk c at [c*22 +: 22] |

## Verification
If the position counter slips, the position part of `par_lo` takes the wrong value on the very next accepted byte with a set bit. If the counter fails to stop at the page end, the chunk results move one cycle after a byte that should have been dropped. If the two parity words fall out of step, `par_hi ^ par_lo` stops being all-zeros or all-ones in the cycle after the faulty update. The bench feeds bytes with a single set bit at chosen positions, runs full pages in both page sizes, and compares the codes of two pages that differ in one bit, so each of these faults appears as a wrong output value within one cycle.

// File: rtl/ecc_gen_pkg.sv
package ecc_gen_pkg;
    localparam int unsigned BYTE_BITS   = 8;
    localparam int unsigned CHUNK_BYTES = 256;
    localparam int unsigned MAX_CHUNKS  = 2;
    localparam int unsigned CLR_CYCLES  = 2;

    localparam int unsigned BIT_IDX_W   = $clog2(BYTE_BITS);
    localparam int unsigned BYTE_IDX_W  = $clog2(CHUNK_BYTES);
    localparam int unsigned PAR_W       = BIT_IDX_W + BYTE_IDX_W;
    localparam int unsigned CODE_W      = 2 * PAR_W;
    localparam int unsigned CHUNK_IDX_W = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1;
    localparam int unsigned CLR_CNT_W   = $clog2(CLR_CYCLES + 1);

    typedef logic [PAR_W-1:0] par_t;

    typedef struct packed {
        logic [BYTE_IDX_W-1:0]  pos;
        logic [CHUNK_IDX_W-1:0] chunk;
        logic                   full;
    } seq_t;

    typedef struct packed {
        par_t lo;
        par_t hi;
    } acc_t;

    typedef struct packed {
        logic [CLR_CNT_W-1:0] cnt;
    } clr_t;
endpackage

// File: rtl/ecc_byte_term.sv
module ecc_byte_term
    import ecc_gen_pkg::*;
(
    input  logic [BYTE_BITS-1:0]  dat_i,
    input  logic [BYTE_IDX_W-1:0] pos_i,
    output par_t                  term_lo_o,
    output par_t                  term_hi_o
);
    logic odd;
    logic [BIT_IDX_W-1:0] col;

    // Column part: each bit-index bit is the parity of data bits whose index has it set
    always_comb begin
        odd = ^dat_i;
        col = '0;
        for (int j = 0; j < int'(BIT_IDX_W); j++) begin
            for (int k = 0; k < int'(BYTE_BITS); k++) begin
                if (((k >> j) & 1) == 1) begin
                    col[j] = col[j] ^ dat_i[k];
                end
            end
        end
        // Row part: byte index appears once per set bit, survives only if count is odd
        term_lo_o = {pos_i & {BYTE_IDX_W{odd}}, col};
        // Complement address per set bit equals address ^ all-ones
        term_hi_o = term_lo_o ^ {PAR_W{odd}};
    end
endmodule

// File: rtl/ecc_clr_ctl.sv
module ecc_clr_ctl
    import ecc_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req_i,
    output logic busy_o
);
    clr_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clr_req_i) begin
            c_d.cnt = CLR_CNT_W'(CLR_CYCLES);
        end else if (c_q.cnt != '0) begin
            c_d.cnt = c_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_o = (c_q.cnt != '0);

    // R8: busy follows a request on the next edge
    p_busy_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |=> busy_o);

    generate
        if (CLR_CYCLES == 2) begin : g_two_cycle_chk
            // R8: busy lasts exactly two cycles after a lone request
            p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (busy_o && !clr_req_i && $past(busy_o) && !$past(clr_req_i)) |=> !busy_o);
        end
    endgenerate
endmodule

// File: rtl/ecc_stream_seq.sv
module ecc_stream_seq
    import ecc_gen_pkg::*;
#(
    parameter int unsigned NUM_CHUNKS = MAX_CHUNKS
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clr_req_i,
    input  logic                   busy_i,
    input  logic                   wide_i,
    input  logic                   vld_i,
    output logic                   take_o,
    output logic [BYTE_IDX_W-1:0]  pos_o,
    output logic [CHUNK_IDX_W-1:0] chunk_o
);
    localparam int unsigned LAST_CHUNK = NUM_CHUNKS - 1;

    seq_t s_d, s_q;
    logic [CHUNK_IDX_W-1:0] limit;
    logic take;

    always_comb begin
        s_d   = s_q;
        limit = wide_i ? CHUNK_IDX_W'(LAST_CHUNK) : '0;
        take  = vld_i && !clr_req_i && !busy_i && !s_q.full;
        if (clr_req_i) begin
            s_d = '0;
        end else if (take) begin
            s_d.pos = s_q.pos + 1'b1;
            if (s_q.pos == BYTE_IDX_W'(CHUNK_BYTES - 1)) begin
                if (s_q.chunk >= limit) s_d.full  = 1'b1;
                else                    s_d.chunk = s_q.chunk + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign take_o  = take;
    assign pos_o   = s_q.pos;
    assign chunk_o = s_q.chunk;

    // R6/R7: once the page is complete it stays complete until cleared
    p_full_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && !clr_req_i) |=> s_q.full);

    // R9: a busy cycle never advances the position
    p_busy_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i && !clr_req_i) |=> $stable(s_q));

    // R8: a request returns the position to zero
    p_clear_pos_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req_i |=> (s_q == '0));
endmodule

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc
    import ecc_gen_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic en_i,
    input  par_t term_lo_i,
    input  par_t term_hi_i,
    output par_t lo_o,
    output par_t hi_o
);
    acc_t a_d, a_q;

    always_comb begin
        a_d = a_q;
        if (clr_i) begin
            a_d = '0;
        end else if (en_i) begin
            a_d.lo = a_q.lo ^ term_lo_i;
            a_d.hi = a_q.hi ^ term_hi_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign lo_o = a_q.lo;
    assign hi_o = a_q.hi;

    // R3: complement word differs from direct word by all-zeros or all-ones
    p_pair_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((a_q.lo ^ a_q.hi) == '0) || ((a_q.lo ^ a_q.hi) == '1));

    // R11: no enable and no clear keeps the words
    p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i && !clr_i) |=> $stable(a_q));
endmodule

// File: rtl/chunk_ecc_gen.sv
module chunk_ecc_gen
    import ecc_gen_pkg::*;
#(
    parameter int unsigned NUM_CHUNKS = MAX_CHUNKS
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr_req,
    output logic                         clr_busy,
    input  logic                         page_wide,
    input  logic                         byte_vld,
    input  logic [BYTE_BITS-1:0]         byte_dat,
    output logic [NUM_CHUNKS*PAR_W-1:0]  par_lo,
    output logic [NUM_CHUNKS*PAR_W-1:0]  par_hi,
    output logic [NUM_CHUNKS*CODE_W-1:0] code
);
    logic                   busy;
    logic                   take;
    logic [BYTE_IDX_W-1:0]  pos;
    logic [CHUNK_IDX_W-1:0] chunk;
    par_t                   term_lo, term_hi;

    ecc_clr_ctl u_clr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req_i (clr_req),
        .busy_o    (busy)
    );

    ecc_stream_seq #(.NUM_CHUNKS(NUM_CHUNKS)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_req_i (clr_req),
        .busy_i    (busy),
        .wide_i    (page_wide),
        .vld_i     (byte_vld),
        .take_o    (take),
        .pos_o     (pos),
        .chunk_o   (chunk)
    );

    ecc_byte_term u_term (
        .dat_i     (byte_dat),
        .pos_i     (pos),
        .term_lo_o (term_lo),
        .term_hi_o (term_hi)
    );

    generate
        for (genvar c = 0; c < int'(NUM_CHUNKS); c++) begin : g_chunk
            logic en;
            par_t lo, hi;
            assign en = take && (chunk == CHUNK_IDX_W'(c));
            ecc_chunk_acc u_acc (
                .clk       (clk),
                .rst_n     (rst_n),
                .clr_i     (clr_req),
                .en_i      (en),
                .term_lo_i (term_lo),
                .term_hi_i (term_hi),
                .lo_o      (lo),
                .hi_o      (hi)
            );
            assign par_lo[c*PAR_W +: PAR_W]   = lo;
            assign par_hi[c*PAR_W +: PAR_W]   = hi;
            assign code[c*CODE_W +: CODE_W]   = {hi, lo};
        end
    endgenerate

    assign clr_busy = busy;

    // R8: a request leaves every word zero on the next cycle
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_req |=> ((par_lo == '0) && (par_hi == '0)));

    // R9: bytes offered while busy do not reach the words
    p_busy_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_busy && !clr_req) |=> ((par_lo == '0) && (par_hi == '0)));

    // R11: idle input keeps the outputs
    p_idle_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_vld && !clr_req) |=> ($stable(par_lo) && $stable(par_hi)));
endmodule

// File: tb/chunk_ecc_gen_bench.sv
`timescale 1ns/1ps
module chunk_ecc_gen_bench;
    localparam int NC = 2;
    localparam int PW = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_req = 1'b0;
    logic clr_busy;
    logic page_wide = 1'b0;
    logic byte_vld = 1'b0;
    logic [7:0] byte_dat = '0;
    logic [NC*PW-1:0] par_lo, par_hi;
    logic [NC*2*PW-1:0] code;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    chunk_ecc_gen u_chunk_ecc_gen (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .clr_busy(clr_busy),
        .page_wide(page_wide), .byte_vld(byte_vld), .byte_dat(byte_dat),
        .par_lo(par_lo), .par_hi(par_hi), .code(code)
    );

    // {pos[7:0], data[7:0], expected lo[10:0], expected hi[10:0]}
    localparam logic [37:0] VEC [8] = '{
        {8'd0,   8'h01, 11'h000, 11'h7FF},
        {8'd0,   8'h80, 11'h007, 11'h7F8},
        {8'd5,   8'h03, 11'h001, 11'h001},
        {8'd255, 8'h04, 11'h7FA, 11'h005},
        {8'd3,   8'hFF, 11'h000, 11'h000},
        {8'd128, 8'h10, 11'h404, 11'h3FB},
        {8'd17,  8'h07, 11'h08B, 11'h774},
        {8'd64,  8'hA0, 11'h002, 11'h002}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        byte_vld = 1'b1;
        byte_dat = b;
    endtask

    task automatic rest();
        @(negedge clk);
        byte_vld = 1'b0;
        byte_dat = '0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        byte_vld = 1'b0;
        clr_req  = 1'b1;
        @(negedge clk);
        clr_req  = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    initial begin
        #800000;
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [21:0] code_a, code_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1 par_lo", 32'(par_lo), 0);
        chk("R1 par_hi", 32'(par_hi), 0);
        chk("R1 code", 32'(code[31:0]), 0);
        chk("R1 code top", 32'(code[43:32]), 0);
        chk("R1 busy", 32'(clr_busy), 0);

        // R2 R3 R4: single byte at chosen positions, table walk
        for (int v = 0; v < 8; v++) begin
            do_clear();
            for (int i = 0; i < int'(VEC[v][37:30]); i++) put(8'h00);
            put(VEC[v][29:22]);
            rest();
            chk("R2 direct word", 32'(par_lo[10:0]), 32'(VEC[v][21:11]));
            chk("R3 complement word", 32'(par_hi[10:0]), 32'(VEC[v][10:0]));
            chk("R4 packed code", 32'(code[21:0]), 32'({VEC[v][10:0], VEC[v][21:11]}));
        end

        // R10: one flipped bit at byte 77 bit 6
        page_wide = 1'b0;
        do_clear();
        for (int i = 0; i < 256; i++) put(pat(i));
        rest();
        code_a = code[21:0];
        do_clear();
        for (int i = 0; i < 256; i++) put((i == 77) ? (pat(i) ^ 8'h40) : pat(i));
        rest();
        code_b = code[21:0];
        chk("R10 syndrome address", 32'((code_a ^ code_b) & 22'h7FF), 32'((77 << 3) | 6));
        chk("R10 syndrome complement", 32'((code_a ^ code_b) >> 11), 32'(((77 << 3) | 6) ^ 11'h7FF));

        // R5 R7: 512-byte mode, byte 520 must be dropped
        page_wide = 1'b1;
        do_clear();
        for (int i = 0; i < 600; i++) put((i == 10) ? 8'h01 : (i == 300) ? 8'h02 : (i == 520) ? 8'h80 : 8'h00);
        rest();
        chk("R5 chunk0 lo", 32'(par_lo[10:0]), 32'h050);
        chk("R5 chunk1 lo", 32'(par_lo[21:11]), 32'h161);
        chk("R5 chunk1 hi", 32'(par_hi[21:11]), 32'h69E);
        chk("R7 chunk0 hi after page end", 32'(par_hi[10:0]), 32'h7AF);

        // R6: 256-byte mode
        page_wide = 1'b0;
        do_clear();
        for (int i = 0; i < 600; i++) put((i == 10) ? 8'h01 : (i == 300) ? 8'h02 : (i == 520) ? 8'h80 : 8'h00);
        rest();
        chk("R6 chunk0 lo", 32'(par_lo[10:0]), 32'h050);
        chk("R6 chunk1 lo", 32'(par_lo[21:11]), 0);
        chk("R6 chunk1 hi", 32'(par_hi[21:11]), 0);

        // R8 R9: clear sequencing with bytes offered throughout
        @(negedge clk);
        clr_req = 1'b1; byte_vld = 1'b1; byte_dat = 8'h80;
        @(negedge clk);
        clr_req = 1'b0;
        chk("R8 busy cycle 1", 32'(clr_busy), 1);
        chk("R8 cleared", 32'(par_lo), 0);
        @(negedge clk);
        chk("R8 busy cycle 2", 32'(clr_busy), 1);
        chk("R9 dropped while busy", 32'(par_lo[10:0]), 0);
        @(negedge clk);
        chk("R8 busy ends", 32'(clr_busy), 0);
        chk("R9 dropped second busy byte", 32'(par_hi[10:0]), 0);
        byte_dat = 8'h04;
        @(negedge clk);
        byte_vld = 1'b0;
        chk("R9 first byte at position 0", 32'(par_lo[10:0]), 32'h002);
        chk("R2 one-cycle latency hi", 32'(par_hi[10:0]), 32'h7FD);

        // R11: idle cycles hold
        repeat (5) @(negedge clk);
        chk("R11 idle lo", 32'(par_lo[10:0]), 32'h002);
        chk("R11 idle hi", 32'(par_hi[10:0]), 32'h7FD);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule